// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block holds the interrupt flags and the interrupt enables for one timer. The timer runs either as an 8-bit counter with two compare channels or as a 16-bit counter in which both compare registers together form one 16-bit value. The counter, the comparators and the capture logic sit outside this block. It receives only their single-cycle event pulses and the two mode signals: wide (16-bit) mode and input-capture mode.

A flag is set by its event pulse, unless the current mode rules that source out. A flag is cleared in one of two ways. Software can write a one to the flag's bit. Alternatively, the interrupt controller can acknowledge the vector of that source.

Each source drives its own request line. A request is high while the global interrupt enable, the source's enable bit and the source's flag are all set. The flag and enable registers are visible on output ports, so that the bus read path can return them.

Top module: `tif_ctrl`

## Requirements
- R1: After reset, flag_q, enable_q and irq are all zero.
- R2: An event pulse that the mode permits sets its flag on the next clock edge. The flag bit positions are: compare A at bit 4, compare B at bit 3, overflow at bit 1, input capture at bit 0.
- R3: A bus write with wr_sel=0 clears every flag whose data bit is one. Flags whose data bit is zero are left unchanged. Flag bits 7, 6, 5 and 2 always read zero.
- R4: An acknowledge pulse clears the flag of its source on the next edge. The ack bit index order is: 0 capture, 1 overflow, 2 compare B, 3 compare A.
- R5: If a permitted event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R6: irq bit i (same index order as ack) is high exactly when gie, the enable bit of source i and the flag of source i are all one, in the same cycle as the flag.
- R7: While mode_capture is 1, a compare A event does not set the compare A flag.
- R8: While mode_wide is 1, a compare B event does not set the compare B flag, while a compare A event still sets its flag.
- R9: Overflow and capture events set their flags in every combination of mode_wide and mode_capture.
- R10: A bus write with wr_sel=1 loads enable bits 4, 3, 1 and 0 from the data, and the other enable bits read zero. A write to one register never changes the other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_cmpa | input | 1 | Compare A match pulse (8-bit match, or the 16-bit match in wide mode) |
| evt_cmpb | input | 1 | Compare B match pulse |
| evt_ovf | input | 1 | Counter overflow pulse |
| evt_cap | input | 1 | Input capture pulse |
| mode_wide | input | 1 | 16-bit mode: compare register B acts as the high byte |
| mode_capture | input | 1 | Input-capture mode: compare register A acts as the capture register |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | Write target: 0 = flag register, 1 = enable register |
| wr_data | input | 8 | Bus write data |
| ack | input | 4 | Per-source vector acknowledge pulses |
| gie | input | 1 | Global interrupt enable |
| flag_q | output | 8 | Flag register contents |
| enable_q | output | 8 | Enable register contents |
| irq | output | 4 | Per-source interrupt requests |

## Verification
Directed sequences try the main function with the following patterns:
- All four events raised together in 8-bit mode. This shows the bit placement of each flag.
- Single-bit write-one clears and all-zero writes. These show the clear action apart from a no-op.
- Acknowledges alone, and acknowledges arriving in the same cycle as an event. These show the clear path apart from the set-priority rule.
- Compare events under each mode combination. These separate the per-mode suppression of compare A from that of compare B, while showing that overflow and capture never suppress.

Constrained random traffic then mixes events, writes, acknowledges, modes and gie. Every cycle is compared against a bench model, which catches interactions that the directed cases do not reach.

// File: rtl/tif_pkg.sv
// Package: shared constants and helpers for the timer interrupt flag controller.
// Assumes a byte-wide register bus and four interrupt sources.
package tif_pkg;
    localparam int REG_W    = 8;
    localparam int N_SRC    = 4;
    localparam int SRC_CAP  = 0;
    localparam int SRC_OVF  = 1;
    localparam int SRC_CMPB = 2;
    localparam int SRC_CMPA = 3;

    // Source index to register bit position (shared by flag and enable registers).
    function automatic int src_pos(input int s);
        case (s)
            SRC_CAP:  return 0;
            SRC_OVF:  return 1;
            SRC_CMPB: return 3;
            default:  return 4;
        endcase
    endfunction

    // Mode inputs grouped.
    typedef struct packed {
        logic wide;
        logic capture;
    } tif_mode_t;
endpackage

// File: rtl/tif_event_gate.sv
// Module: tif_event_gate
// Filters raw event pulses by timer mode. Compare A is blocked in capture
// mode, compare B is blocked in wide mode, and the others always pass.
// Assumes events are single-cycle pulses.
module tif_event_gate
    import tif_pkg::*;
#(
    parameter int NS = N_SRC
) (
    input  logic [NS-1:0] evt_i,
    input  tif_mode_t     mode_i,
    output logic [NS-1:0] set_o
);
    for (genvar s = 0; s < NS; s++) begin : g_src
        if (s == SRC_CMPA) begin : g_a
            // compare A: no set while register A serves as capture register
            always_comb set_o[s] = evt_i[s] & ~mode_i.capture;
        end else if (s == SRC_CMPB) begin : g_b
            // compare B: no set while register B is the high byte
            always_comb set_o[s] = evt_i[s] & ~mode_i.wide;
        end else begin : g_pass
            // overflow and capture: no mode suppression
            always_comb set_o[s] = evt_i[s];
        end
    end
endmodule

// File: rtl/tif_flag_cell.sv
// Module: tif_flag_cell
// One interrupt flag bit. The set input has priority over the clear input,
// so that an event arriving in the same cycle as a clear is not lost.
// Synchronous active-low reset.
module tif_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // flag update: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/tif_enable_reg.sv
// Module: tif_enable_reg
// Per-source enable bits, loaded as a whole on a write strobe.
// Synchronous active-low reset.
module tif_enable_reg #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [NS-1:0] data_i,
    output logic [NS-1:0] en_o
);
    // enable storage
    always_ff @(posedge clk) begin
        if (!rst_n)    en_o <= '0;
        else if (wr_i) en_o <= data_i;
    end
endmodule

// File: rtl/tif_ctrl.sv
// Module: tif_ctrl (top)
// Interrupt flag and enable registers for one timer, with per-source
// requests. Flags are set by mode-gated event pulses and cleared by a
// write-one or a vector acknowledge. Requests are combinational from the
// registers and gie. Assumes wr_data bit positions follow tif_pkg::src_pos.
module tif_ctrl
    import tif_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int NS = N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_cmpa,
    input  logic          evt_cmpb,
    input  logic          evt_ovf,
    input  logic          evt_cap,
    input  logic          mode_wide,
    input  logic          mode_capture,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic [NS-1:0] ack,
    input  logic          gie,
    output logic [DW-1:0] flag_q,
    output logic [DW-1:0] enable_q,
    output logic [NS-1:0] irq
);
    logic [NS-1:0] evt_vec, set_vec, clr_vec, flag_vec, en_vec, wdat_src;
    tif_mode_t     mode;
    logic          flag_wr, en_wr;

    // gather raw events and modes
    always_comb begin
        evt_vec           = '0;
        evt_vec[SRC_CAP]  = evt_cap;
        evt_vec[SRC_OVF]  = evt_ovf;
        evt_vec[SRC_CMPB] = evt_cmpb;
        evt_vec[SRC_CMPA] = evt_cmpa;
        mode.wide         = mode_wide;
        mode.capture      = mode_capture;
    end

    // decode which register the bus writes
    always_comb begin
        flag_wr = wr_en & ~wr_sel;
        en_wr   = wr_en &  wr_sel;
    end

    tif_event_gate #(.NS(NS)) u_gate (
        .evt_i  (evt_vec),
        .mode_i (mode),
        .set_o  (set_vec)
    );

    for (genvar s = 0; s < NS; s++) begin : g_src
        localparam int P = src_pos(s);
        // pick this source's data bit and build its clear
        always_comb begin
            wdat_src[s] = wr_data[P];
            clr_vec[s]  = (flag_wr & wr_data[P]) | ack[s];
        end

        tif_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[s]),
            .clr_i  (clr_vec[s]),
            .flag_o (flag_vec[s])
        );
    end

    tif_enable_reg #(.NS(NS)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (en_wr),
        .data_i (wdat_src),
        .en_o   (en_vec)
    );

    // scatter per-source state to register layout; unused bits read zero
    always_comb begin
        flag_q   = '0;
        enable_q = '0;
        for (int s = 0; s < NS; s++) begin
            flag_q[src_pos(s)]   = flag_vec[s];
            enable_q[src_pos(s)] = en_vec[s];
        end
    end

    // request generation
    always_comb irq = flag_vec & en_vec & {NS{gie}};
endmodule

// File: rtl/tif_ctrl_chk.sv
// Module: tif_ctrl_chk
// Port-level checker for tif_ctrl, attached with bind below.
module tif_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       evt_cmpa,
    input logic       evt_cmpb,
    input logic       evt_ovf,
    input logic       evt_cap,
    input logic       mode_wide,
    input logic       mode_capture,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic [3:0] ack,
    input logic       gie,
    input logic [7:0] flag_q,
    input logic [7:0] enable_q,
    input logic [3:0] irq
);
    a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ovf |=> flag_q[1]);
    a_r5_cap_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cap && ack[0]) |=> flag_q[0]);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[1] && !evt_ovf) |=> !flag_q[1]);
    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[0] && !evt_cap) |=> !flag_q[0]);
    a_r6_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != 4'd0) |-> gie);
    a_r7_cmpa_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[4]) |-> $past(evt_cmpa && !mode_capture));
    a_r8_cmpb_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[3]) |-> $past(evt_cmpb && !mode_wide));
    a_r10_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel) |=> $stable(enable_q));
endmodule

bind tif_ctrl tif_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb),
    .evt_ovf(evt_ovf), .evt_cap(evt_cap), .mode_wide(mode_wide),
    .mode_capture(mode_capture), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ack(ack), .gie(gie), .flag_q(flag_q),
    .enable_q(enable_q), .irq(irq)
);

// File: tb/tif_ctrl_tb_top.sv
`timescale 1ns/1ps
module tif_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       evt_cmpa, evt_cmpb, evt_ovf, evt_cap;
    logic       mode_wide, mode_capture, wr_en, wr_sel, gie;
    logic [7:0] wr_data;
    logic [3:0] ack;
    logic [7:0] flag_q, enable_q;
    logic [3:0] irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] m_flag = 8'h00;
    logic [7:0] m_en = 8'h00;

    always #4 clk = ~clk;

    tif_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb),
        .evt_ovf(evt_ovf), .evt_cap(evt_cap), .mode_wide(mode_wide),
        .mode_capture(mode_capture), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack(ack), .gie(gie), .flag_q(flag_q),
        .enable_q(enable_q), .irq(irq)
    );

    // Source index i -> bit position: 0->0, 1->1, 2->3, 3->4
    function automatic logic [7:0] spread(input logic [3:0] v);
        return {3'b000, v[3], v[2], 1'b0, v[1], v[0]};
    endfunction

    function automatic logic [3:0] gather(input logic [7:0] r);
        return {r[4], r[3], r[1], r[0]};
    endfunction

    function automatic logic [7:0] next_flag(input logic [7:0] f, input logic [3:0] ev,
            input logic wide, input logic cap, input logic we, input logic sel,
            input logic [7:0] d, input logic [3:0] ak);
        logic [3:0] set = {ev[3] & ~cap, ev[2] & ~wide, ev[1], ev[0]};
        logic [7:0] clr = ((we && !sel) ? d : 8'h00) | spread(ak);
        return ((f & ~clr) | spread(set)) & 8'h1B;
    endfunction

    // Drive one cycle's inputs (ev index: 0 cap, 1 ovf, 2 cmpB, 3 cmpA) and advance the model
    task automatic apply(input logic [3:0] ev, input logic wide, input logic cap,
            input logic we, input logic sel, input logic [7:0] d,
            input logic [3:0] ak, input logic g);
        {evt_cmpa, evt_cmpb, evt_ovf, evt_cap} = ev;
        mode_wide = wide; mode_capture = cap; wr_en = we; wr_sel = sel;
        wr_data = d; ack = ak; gie = g;
        m_flag = next_flag(m_flag, ev, wide, cap, we, sel, d, ak);
        if (we && sel) m_en = d & 8'h1B;
        @(negedge clk);
    endtask

    task automatic check(input string tag);
        logic [3:0] e_irq = gather(m_flag) & gather(m_en) & {4{gie}};
        n_chk++;
        if (flag_q !== m_flag || enable_q !== m_en || irq !== e_irq) begin
            n_fail++;
            $display("FAIL %s flag=%h en=%h irq=%b expected flag=%h en=%h irq=%b",
                     tag, flag_q, enable_q, irq, m_flag, m_en, e_irq);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        {evt_cmpa, evt_cmpb, evt_ovf, evt_cap} = 4'h0;
        mode_wide = 0; mode_capture = 0; wr_en = 0; wr_sel = 0;
        wr_data = 8'h00; ack = 4'h0; gie = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        // R10: enable write keeps only bits 4,3,1,0
        apply(4'h0, 0, 0, 1, 1, 8'hFF, 4'h0, 1); check("R10");
        // R2: all events in 8-bit mode; R6 all requests
        apply(4'hF, 0, 0, 0, 0, 8'h00, 4'h0, 1); check("R2");
        check("R6");
        // R3: write-one clears overflow only, reserved bits read zero
        apply(4'h0, 0, 0, 1, 0, 8'hE6, 4'h0, 1); check("R3");
        apply(4'h0, 0, 0, 1, 0, 8'h00, 4'h0, 1); check("R3");
        // R4: ack of compare A
        apply(4'h0, 0, 0, 0, 0, 8'h00, 4'b1000, 1); check("R4");
        // R5: capture event with ack and write-one on the same cycle
        apply(4'b0001, 0, 0, 1, 0, 8'h01, 4'b0001, 1); check("R5");
        // R6: gie low masks all requests
        apply(4'h0, 0, 0, 0, 0, 8'h00, 4'h0, 0); check("R6");
        // R7: clear all, then compare A in capture mode
        apply(4'h0, 0, 0, 1, 0, 8'hFF, 4'h0, 1); check("R3");
        apply(4'b1000, 0, 1, 0, 0, 8'h00, 4'h0, 1); check("R7");
        // R8: wide mode blocks compare B, passes compare A
        apply(4'b1100, 1, 0, 0, 0, 8'h00, 4'h0, 1); check("R8");
        // R9: overflow and capture in wide+capture mode
        apply(4'b0011, 1, 1, 0, 0, 8'h00, 4'h0, 1); check("R9");
        // R10: enable write of zero leaves flags; flag write leaves enables
        apply(4'h0, 0, 0, 1, 1, 8'h00, 4'h0, 1); check("R10");
        apply(4'h0, 0, 0, 1, 1, 8'h09, 4'h0, 1); check("R10");
        apply(4'h0, 0, 0, 1, 0, 8'h1B, 4'h0, 1); check("R10");
        // mixed random traffic covering R2..R10
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ev = 4'($urandom);
            logic we = ($urandom % 4) == 0;
            logic [3:0] ak = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            apply(ev, 1'($urandom), 1'($urandom), we, 1'($urandom),
                  8'($urandom), ak, ($urandom % 4) != 0);
            check("RMIX");
        end
        finish_run();
    end
endmodule